// File: doc/BRIEF.md
# Triggered Analog Memory Column Controller

This block steers a column-switched analog sample memory that many self-triggering channels share. Any channel discriminator that fires starts a capture in the current column. For a fixed number of cycles the block gathers the pattern of channels that fired into that column's hit word. It also stores the bunch-crossing counter for the column and then issues a one-cycle hold strobe. The strobe stands for the analog hold switches of that column. The column pointer advances on the next slow-clock tick. The column then waits for a verdict from the acquisition system.

A validate pulse keeps the column. A no-trigger pulse erases it: the column's hit word and its stored crossing number are cleared, and the pointer steps back so that the column is used again. A column that gets no verdict within the validation window is erased in the same way. When every column holds a kept event, the block raises the memory-full flag and ignores all further triggers. A read index gives combinational access to the stored hit word and crossing number of any column.

Top module: `amem_column_ctrl`

## Requirements
- R1: After reset, col_addr is 0, and hold_stb, ram_full and val_pending are all 0. Every column reads back a hit word of 0 and a crossing number of 0.
- R2: While idle and not full, a nonzero disc vector starts a capture in column col_addr. The column's hit word becomes the bitwise OR of disc over the trigger cycle and the following HOLD_DLY cycles.
- R3: An 8-bit crossing counter starts at 0 and adds 1, wrapping, on every cycle in which bx_tick is high. A capture stores the counter value of its trigger cycle in the column.
- R4: hold_stb is high for exactly one cycle, HOLD_DLY clock cycles after the trigger cycle.
- R5: col_addr stays on the captured column after the hold. It advances by one only on the first bx_tick after the hold, and val_pending rises at the same time.
- R6: A validate pulse while val_pending is high keeps the column's contents, clears val_pending and leaves col_addr on the next column.
- R7: A no_trig pulse while val_pending is high clears the pending column's hit word and crossing number to 0. It also returns col_addr to that column and clears val_pending.
- R8: If neither validate nor no_trig arrives, the pending column is erased as in R7 at the VAL_WIN-th clock edge after the advancing tick. validate and no_trig are still honoured up to that edge.
- R9: When all DEPTH columns hold kept or pending events, ram_full is 1 and col_addr holds at DEPTH-1.
- R10: Trigger activity is ignored while a capture, a wait for the tick or a validation is in progress, and whenever ram_full is 1. No hold_stb pulse follows, and no column contents change.
- R11: When validate and no_trig are both high in the same pending cycle, validate wins and the column is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bx_tick | input | 1 | One-cycle pulse marking a slow-clock (bunch-crossing) edge |
| disc | input | NCH | Channel discriminator outputs |
| validate | input | 1 | Acquisition system accepts the pending column |
| no_trig | input | 1 | Acquisition system rejects the pending column |
| rd_col | input | log2(DEPTH) | Column selected for read-back |
| col_addr | output | log2(DEPTH) | Current write column |
| hold_stb | output | 1 | One-cycle analog hold strobe |
| ram_full | output | 1 | All columns occupied |
| val_pending | output | 1 | Last column awaits a verdict |
| rd_hits | output | NCH | Hit word of column rd_col |
| rd_bcid | output | 8 | Stored crossing number of column rd_col |

## Verification
A miscounted hold delay shows up as hold_stb on the wrong cycle within a few cycles of the trigger. A pointer that slips, by advancing without a tick or failing to step back on an erase, shows at col_addr the cycle after the tick or verdict. It also shows later as hit words landing in the wrong column on read-back. A wrong occupancy count becomes visible as ram_full rising one column early or late. A timeout counter that is off by one is caught by sampling val_pending on the edge before and on the edge after the window limit.

// File: rtl/amem_column_ctrl.sv
module amem_column_ctrl #(
  parameter int NCH      = 36,
  parameter int DEPTH    = 16,
  parameter int BCW      = 8,
  parameter int HOLD_DLY = 5,
  parameter int VAL_WIN  = 500
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bx_tick,
  input  logic [NCH-1:0]           disc,
  input  logic                     validate,
  input  logic                     no_trig,
  input  logic [$clog2(DEPTH)-1:0] rd_col,
  output logic [$clog2(DEPTH)-1:0] col_addr,
  output logic                     hold_stb,
  output logic                     ram_full,
  output logic                     val_pending,
  output logic [NCH-1:0]           rd_hits,
  output logic [BCW-1:0]           rd_bcid
);
  localparam int AW = $clog2(DEPTH);
  localparam int HW = $clog2(HOLD_DLY + 1);
  localparam int WW = $clog2(VAL_WIN + 1);

  typedef enum logic [1:0] {S_IDLE, S_CAPT, S_ARM, S_PEND} st_t;

  st_t            st;
  logic [AW:0]    used;
  logic [BCW-1:0] bcid;
  logic [HW-1:0]  hcnt;
  logic [WW-1:0]  wcnt;
  logic [NCH-1:0] hit_mem  [DEPTH];
  logic [BCW-1:0] bcid_mem [DEPTH];

  wire          trig = |disc;
  wire [AW-1:0] wcol = used[AW-1:0];
  wire [AW-1:0] lcol = wcol - 1'b1;

  assign ram_full    = (used == (AW+1)'(DEPTH));
  assign col_addr    = ram_full ? AW'(DEPTH-1) : wcol;
  assign val_pending = (st == S_PEND);
  assign rd_hits     = hit_mem[rd_col];
  assign rd_bcid     = bcid_mem[rd_col];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      used     <= '0;
      bcid     <= '0;
      hcnt     <= '0;
      wcnt     <= '0;
      hold_stb <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        hit_mem[i]  <= '0;
        bcid_mem[i] <= '0;
      end
    end else begin
      hold_stb <= 1'b0;
      if (bx_tick) bcid <= bcid + 1'b1;
      case (st)
        S_IDLE: if (trig && !ram_full) begin
          hit_mem[wcol]  <= disc;
          bcid_mem[wcol] <= bcid;
          hcnt           <= '0;
          st             <= S_CAPT;
        end
        S_CAPT: begin
          hit_mem[wcol] <= hit_mem[wcol] | disc;
          if (hcnt == HW'(HOLD_DLY-1)) begin
            hold_stb <= 1'b1;
            st       <= S_ARM;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        S_ARM: if (bx_tick) begin
          used <= used + 1'b1;
          wcnt <= '0;
          st   <= S_PEND;
        end
        S_PEND: begin
          if (validate) begin
            st <= S_IDLE;
          end else if (no_trig || wcnt == WW'(VAL_WIN-1)) begin
            hit_mem[lcol]  <= '0;
            bcid_mem[lcol] <= '0;
            used           <= used - 1'b1;
            st             <= S_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_stb |=> !hold_stb);

  assert_advance_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && used == $past(used) + 1'b1) |-> $past(bx_tick));

  assert_bcid_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bx_tick)) |-> bcid == $past(bcid) + 1'b1);

  assert_erase_shrinks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(st) == S_PEND && $past(no_trig) && !$past(validate))
      |-> used == $past(used) - 1'b1);

  assert_full_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_full |-> col_addr == AW'(DEPTH-1));

  assert_full_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && ram_full) |=> st == S_IDLE);

  assert_validate_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PEND && validate) |=> used == $past(used));
endmodule

// File: tb/amem_column_ctrl_tb.sv
module amem_column_ctrl_tb;
  localparam int NCH = 36, DEPTH = 16, HD = 5, VW = 40;

  logic clk = 0, rst_n = 0, bx_tick = 0, validate = 0, no_trig = 0;
  logic [NCH-1:0] disc = '0;
  logic [3:0] rd_col = '0;
  logic [3:0] col_addr;
  logic hold_stb, ram_full, val_pending;
  logic [NCH-1:0] rd_hits;
  logic [7:0] rd_bcid;

  int nchk = 0, nerr = 0, exp_bx = 0;
  logic [NCH-1:0] exp_hits [DEPTH];
  logic [7:0]     exp_bc   [DEPTH];

  always #5 clk = ~clk;

  amem_column_ctrl #(.NCH(NCH), .DEPTH(DEPTH), .BCW(8), .HOLD_DLY(HD), .VAL_WIN(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bx_tick(bx_tick), .disc(disc), .validate(validate),
    .no_trig(no_trig), .rd_col(rd_col), .col_addr(col_addr), .hold_stb(hold_stb),
    .ram_full(ram_full), .val_pending(val_pending), .rd_hits(rd_hits), .rd_bcid(rd_bcid));

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); bx_tick = 1;
    @(negedge clk); bx_tick = 0;
    exp_bx++;
  endtask

  task automatic pulse(input bit v, input bit n);
    @(negedge clk); validate = v; no_trig = n;
    @(negedge clk); validate = 0; no_trig = 0;
  endtask

  task automatic check_col(input int c, input string rq);
    @(negedge clk); rd_col = 4'(c); #1;
    chk({rq, " hits"}, 64'(rd_hits), 64'(exp_hits[c]));
    chk({rq, " bcid"}, 64'(rd_bcid), 64'(exp_bc[c]));
  endtask

  // trigger with pattern a, add pattern b one cycle later, then tick to advance
  task automatic capture(input int c, input logic [NCH-1:0] a, input logic [NCH-1:0] b);
    @(negedge clk); disc = a;
    exp_bc[c] = 8'(exp_bx);
    for (int i = 1; i <= HD + 2; i++) begin
      @(negedge clk);
      if (i == 1) disc = b; else disc = '0;
      chk("R4 hold timing", 64'(hold_stb), 64'(i == HD + 1));
    end
    exp_hits[c] = a | b;
    repeat (3) @(negedge clk);
    chk("R5 no advance before tick", 64'(col_addr), 64'(c));
    chk("R5 not pending before tick", 64'(val_pending), 64'd0);
    tick();
    chk("R5 advance on tick", 64'(col_addr), 64'((c + 1 < DEPTH) ? c + 1 : DEPTH - 1));
    chk("R5 pending after tick", 64'(val_pending), 64'd1);
  endtask

  task automatic t_reset();
    chk("R1 col_addr", 64'(col_addr), 64'd0);
    chk("R1 hold", 64'(hold_stb), 64'd0);
    chk("R1 full", 64'(ram_full), 64'd0);
    chk("R1 pending", 64'(val_pending), 64'd0);
    for (int c = 0; c < DEPTH; c++) begin
      exp_hits[c] = '0; exp_bc[c] = '0;
      check_col(c, "R1 cleared column");
    end
  endtask

  task automatic t_validate();
    repeat (3) tick();
    capture(0, 36'h0_0000_0011, 36'h8_0000_0100);
    pulse(1, 0);
    chk("R6 pending cleared", 64'(val_pending), 64'd0);
    chk("R6 col_addr kept", 64'(col_addr), 64'd1);
    check_col(0, "R2 R3 R6 column 0");
  endtask

  task automatic t_notrig();
    tick();
    capture(1, 36'h0_00F0_0000, 36'h0);
    pulse(0, 1);
    exp_hits[1] = '0; exp_bc[1] = '0;
    chk("R7 col_addr back", 64'(col_addr), 64'd1);
    chk("R7 pending cleared", 64'(val_pending), 64'd0);
    check_col(1, "R7 erased column");
  endtask

  task automatic t_timeout();
    capture(1, 36'h1_0000_0000, 36'h0);
    repeat (VW - 1) @(negedge clk);
    chk("R8 still pending at limit-1", 64'(val_pending), 64'd1);
    @(negedge clk);
    chk("R8 erased at limit", 64'(val_pending), 64'd0);
    chk("R8 col_addr back", 64'(col_addr), 64'd1);
    exp_hits[1] = '0; exp_bc[1] = '0;
    check_col(1, "R8 erased column");
  endtask

  task automatic t_both();
    tick(); tick();
    capture(1, 36'h0_0000_0002, 36'h0_0000_0004);
    pulse(1, 1);
    chk("R11 kept col_addr", 64'(col_addr), 64'd2);
    check_col(1, "R11 kept column");
  endtask

  task automatic t_busy();
    capture(2, 36'h0_0001_0000, 36'h0);
    @(negedge clk); disc = 36'hF_FFFF_FFFF;
    @(negedge clk); disc = '0;
    pulse(1, 0);
    for (int i = 0; i < HD + 3; i++) begin
      @(negedge clk);
      chk("R10 no hold while busy", 64'(hold_stb), 64'd0);
    end
    chk("R10 col_addr", 64'(col_addr), 64'd3);
    check_col(2, "R10 busy column intact");
    check_col(3, "R10 next column untouched");
  endtask

  task automatic t_fill();
    for (int c = 3; c < DEPTH; c++) begin
      chk("R9 not full yet", 64'(ram_full), 64'd0);
      capture(c, 36'(c) << (c + 4), 36'h0);
      pulse(1, 0);
      tick();
    end
    chk("R9 full", 64'(ram_full), 64'd1);
    chk("R9 col_addr saturated", 64'(col_addr), 64'd15);
    @(negedge clk); disc = 36'h0_0000_00FF;
    for (int i = 0; i < HD + 3; i++) begin
      @(negedge clk);
      chk("R10 no hold when full", 64'(hold_stb), 64'd0);
    end
    disc = '0;
    chk("R10 not pending when full", 64'(val_pending), 64'd0);
    check_col(15, "R10 full column 15 intact");
    check_col(3, "R2 column 3");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_validate();
    t_notrig();
    t_timeout();
    t_both();
    t_busy();
    t_fill();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule